// File: doc/BRIEF.md
# Packed Halfword Shift Unit

This unit shifts a 32-bit source word as two independent 16-bit lanes, both lanes using the same shift amount. It offers arithmetic and logical right shifts, each with an optional round-to-nearest variant, a plain left shift, a left shift that clamps on overflow, and a bidirectional shift. The bidirectional shift reads a signed amount and shifts left with clamping when the amount is zero or positive. When the amount is negative, it shifts arithmetically right, with or without rounding.

The amount comes from the low bits of a second source word or from a short immediate. When the immediate is used, its top bit promotes a plain shift to its rounding or clamping variant. Any lane that clamps sets a sticky saturation flag, which stays set until a clear request arrives. A parameter chooses whether the result is combinational or held in a register loaded by each valid operation. Fetch, decode and register file access are outside this block.

Top module: `simd16_shift_unit`

## Requirements
- R1: `op_i` selects the operation: 0 arithmetic right, 1 logical right, 2 plain left, 3 rounding arithmetic right, 4 rounding logical right, 5 clamping left, 6 bidirectional, 7 rounding bidirectional. Lane k takes `rs1_i[16k+15:16k]` and writes `rd_o[16k+15:16k]`. Both lanes use one amount and are computed independently.
- R2: With `use_imm_i`=0, operations 0 to 5 use `rs2_i[3:0]` as the amount (0 to 15). All other bits of `rs2_i` have no effect.
- R3: With `use_imm_i`=1, operations 0 to 5 take their amount from `imm_i[3:0]`. When `imm_i[4]`=1, operation 0 becomes 3, 1 becomes 4 and 2 becomes 5. Operations 6 and 7 ignore `use_imm_i` and `imm_i`.
- R4: Arithmetic right fills with the lane's sign bit and logical right fills with zeros. Plain left drops the bits shifted out of the lane. None of these three changes the saturation flag.
- R5: A rounding right shift by n≥1 adds 2^(n-1) to the lane at 17 bits, sign- or zero-extended to match the shift type, and then shifts. A shift by 0 returns the lane unchanged.
- R6: The clamping left shift overflows when n exceeds the number of redundant sign bits of the lane. On overflow the lane becomes 0x8000 for a negative input and 0x7FFF otherwise, and the saturation flag is set.
- R7: The bidirectional operations read `rs2_i[4:0]` as a signed amount d. For d≥0 they perform the clamping left shift by d. For d<0 they perform an arithmetic right shift by |d|, with |d|=16 treated as 15; operation 7 rounds this right shift as in R5.
- R8: `sat_o` becomes 1 at the clock edge after a valid operation in which either lane overflows, and then stays 1. `sat_clr_i` clears it at the next edge unless a saturating valid operation arrives in the same cycle, in which case the flag is set.
- R9: With REGISTERED=1, `rd_o` loads the result at the clock edge where `valid_i`=1 and holds while `valid_i`=0. With REGISTERED=0, `rd_o` follows the inputs combinationally.
- R10: A synchronous active-low reset clears `sat_o` and, with REGISTERED=1, `rd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Operation is issued this cycle |
| op_i | input | 3 | Operation select (R1) |
| rs1_i | input | 32 | Packed source lanes |
| rs2_i | input | 32 | Register shift amount |
| imm_i | input | 5 | Immediate amount [3:0] and variant bit [4] |
| use_imm_i | input | 1 | Take the amount from the immediate |
| sat_clr_i | input | 1 | Clear the sticky saturation flag |
| rd_o | output | 32 | Packed result lanes |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The bench builds two copies with the default lane width of 16 and two lanes: one with REGISTERED=1 and one with REGISTERED=0. Both receive identical stimulus. The combinational copy is compared before the clock edge and the registered copy after it, so both the output timing and the hold-on-idle behaviour are checked. Because the lanes are 16 bits wide, the amounts 0, 1, 15 and the clamped 16 can all be driven directly, in both directions. The bench applies them to the lane values 0x7FFF, 0x8000, 0xFFFF and 0x0001, plus random values.

// File: rtl/simd16_shift_pkg.sv
// Shared types of the packed halfword shift unit.
// Assumes: operation codes are fixed by the issue logic that drives op_i.
package simd16_shift_pkg;

    // Operation codes seen at the unit's edge
    typedef enum logic [2:0] {
        OP_ASR      = 3'd0,
        OP_LSR      = 3'd1,
        OP_SHL      = 3'd2,
        OP_ASR_RND  = 3'd3,
        OP_LSR_RND  = 3'd4,
        OP_SHL_CLMP = 3'd5,
        OP_BIDIR    = 3'd6,
        OP_BIDIR_RND = 3'd7
    } shop_e;

    // Datapath kind each lane executes after decode
    typedef enum logic [1:0] {
        K_ARITH_R = 2'd0,
        K_LOGIC_R = 2'd1,
        K_LEFT    = 2'd2
    } kind_e;

endpackage

// File: rtl/simd16_shift_ctrl.sv
// Operation decode for the packed shift unit.
// Turns op, immediate selection and the amount sources into one lane control set:
// datapath kind, rounding enable, clamping enable and an unsigned amount.
// Assumes: AMT_W = log2(lane width); bidirectional amount is AMT_W+1 bits signed.
module simd16_shift_ctrl
    import simd16_shift_pkg::*;
#(
    parameter int AMT_W = 4
) (
    input  logic [2:0]       op_i,
    input  logic [31:0]      rs2_i,
    input  logic [AMT_W:0]   imm_i,
    input  logic             use_imm_i,
    output kind_e            kind_o,
    output logic             rnd_o,
    output logic             clamp_o,
    output logic [AMT_W-1:0] amt_o
);
    localparam int DIR_W = AMT_W + 1;

    shop_e            op_eff;
    logic [AMT_W-1:0] base_amt;
    logic [DIR_W-1:0] dir_amt;
    logic [DIR_W-1:0] dir_mag;
    logic [AMT_W-1:0] dir_right;

    // Promote plain ops to their variant when the immediate variant bit is set
    always_comb begin
        op_eff = shop_e'(op_i);
        if (use_imm_i && imm_i[AMT_W]) begin
            case (shop_e'(op_i))
                OP_ASR:  op_eff = OP_ASR_RND;
                OP_LSR:  op_eff = OP_LSR_RND;
                OP_SHL:  op_eff = OP_SHL_CLMP;
                default: op_eff = shop_e'(op_i);
            endcase
        end
    end

    // Amount source and signed-amount magnitude with the 16-to-15 clamp
    always_comb begin
        base_amt  = use_imm_i ? imm_i[AMT_W-1:0] : rs2_i[AMT_W-1:0];
        dir_amt   = rs2_i[DIR_W-1:0];
        dir_mag   = -dir_amt;
        dir_right = dir_mag[AMT_W] ? {AMT_W{1'b1}} : dir_mag[AMT_W-1:0];
    end

    // Map the effective operation onto the lane controls
    always_comb begin
        kind_o  = K_ARITH_R;
        rnd_o   = 1'b0;
        clamp_o = 1'b0;
        amt_o   = base_amt;
        case (op_eff)
            OP_ASR:      kind_o = K_ARITH_R;
            OP_LSR:      kind_o = K_LOGIC_R;
            OP_SHL:      kind_o = K_LEFT;
            OP_ASR_RND:  begin kind_o = K_ARITH_R; rnd_o = 1'b1; end
            OP_LSR_RND:  begin kind_o = K_LOGIC_R; rnd_o = 1'b1; end
            OP_SHL_CLMP: begin kind_o = K_LEFT; clamp_o = 1'b1; end
            OP_BIDIR, OP_BIDIR_RND: begin
                if (dir_amt[DIR_W-1]) begin
                    kind_o = K_ARITH_R;
                    rnd_o  = (op_eff == OP_BIDIR_RND);
                    amt_o  = dir_right;
                end else begin
                    kind_o  = K_LEFT;
                    clamp_o = 1'b1;
                    amt_o   = dir_amt[AMT_W-1:0];
                end
            end
            default: kind_o = K_ARITH_R;
        endcase
    end

endmodule

// File: rtl/simd16_lane_shifter.sv
// One lane of the packed shift unit.
// Right path: optional rounding bias added at W+1 bits, then a shift that fills
// with the sign bit or with zeros. Left path: shift in a double-width word, and
// flag overflow when the bits shifted out are not all copies of the sign bit.
// Assumes: amt_i < W.
module simd16_lane_shifter
    import simd16_shift_pkg::*;
#(
    parameter int W     = 16,
    parameter int AMT_W = 4
) (
    input  logic [W-1:0]     a_i,
    input  kind_e            kind_i,
    input  logic             rnd_i,
    input  logic             clamp_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [W-1:0]     res_o,
    output logic             ovf_o
);
    logic [W:0]       ext;
    logic [W:0]       bias;
    logic [W:0]       sum;
    logic [W+1:0]     wide_r;
    logic [W+1:0]     shr;
    logic [2*W-1:0]   lwide;
    logic [W:0]       top;
    logic             nonred;
    logic [W-1:0]     clamp_val;

    // Right path: extend, add the rounding bias, shift with the right fill
    always_comb begin
        ext    = {(kind_i == K_ARITH_R) & a_i[W-1], a_i};
        bias   = (rnd_i && amt_i != '0) ? ((W+1)'(1) << (amt_i - 1'b1)) : '0;
        sum    = ext + bias;
        wide_r = {(kind_i == K_ARITH_R) & sum[W], sum};
        shr    = $unsigned($signed(wide_r) >>> amt_i);
    end

    // Left path: double-width shift and redundant-sign overflow test
    always_comb begin
        lwide     = {{W{a_i[W-1]}}, a_i} << amt_i;
        top       = lwide[2*W-1:W-1];
        nonred    = !((&top) || (~|top));
        clamp_val = a_i[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end

    // Result select
    always_comb begin
        ovf_o = (kind_i == K_LEFT) && clamp_i && nonred;
        if (kind_i == K_LEFT) res_o = ovf_o ? clamp_val : lwide[W-1:0];
        else                  res_o = shr[W-1:0];
    end

endmodule

// File: rtl/simd16_sat_flag.sv
// Sticky saturation flag: set by a valid operation that clamps, cleared on request.
// Setting takes priority over clearing within the same cycle.
// Assumes: synchronous active-low reset.
module simd16_sat_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic hit_i,
    input  logic clr_i,
    output logic sat_o
);
    // Sticky set / explicit clear
    always_ff @(posedge clk) begin
        if (!rst_n)                sat_o <= 1'b0;
        else if (valid_i && hit_i) sat_o <= 1'b1;
        else if (clr_i)            sat_o <= 1'b0;
    end

endmodule

// File: rtl/simd16_shift_unit.sv
// Packed halfword shift unit: LANES lanes of LANE_W bits, one shared amount.
// Decodes the operation once, then runs a replicated lane shifter per lane.
// REGISTERED selects a result register loaded on valid_i or a combinational path.
// Assumes: LANES*LANE_W == 32, LANE_W a power of two.
module simd16_shift_unit #(
    parameter int LANE_W     = 16,
    parameter int LANES      = 2,
    parameter bit REGISTERED = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid_i,
    input  logic [2:0]  op_i,
    input  logic [31:0] rs1_i,
    input  logic [31:0] rs2_i,
    input  logic [4:0]  imm_i,
    input  logic        use_imm_i,
    input  logic        sat_clr_i,
    output logic [31:0] rd_o,
    output logic        sat_o
);
    import simd16_shift_pkg::*;

    localparam int AMT_W  = $clog2(LANE_W);
    localparam int DATA_W = LANE_W * LANES;

    kind_e             kind;
    logic              rnd;
    logic              clamp;
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] res;
    logic [LANES-1:0]  lane_ovf;

    simd16_shift_ctrl #(.AMT_W(AMT_W)) u_ctrl (
        .op_i      (op_i),
        .rs2_i     (rs2_i),
        .imm_i     (imm_i[AMT_W:0]),
        .use_imm_i (use_imm_i),
        .kind_o    (kind),
        .rnd_o     (rnd),
        .clamp_o   (clamp),
        .amt_o     (amt)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        simd16_lane_shifter #(.W(LANE_W), .AMT_W(AMT_W)) u_lane (
            .a_i     (rs1_i[g*LANE_W +: LANE_W]),
            .kind_i  (kind),
            .rnd_i   (rnd),
            .clamp_i (clamp),
            .amt_i   (amt),
            .res_o   (res[g*LANE_W +: LANE_W]),
            .ovf_o   (lane_ovf[g])
        );
    end

    simd16_sat_flag u_sat (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .hit_i   (|lane_ovf),
        .clr_i   (sat_clr_i),
        .sat_o   (sat_o)
    );

    if (REGISTERED) begin : g_reg
        logic [DATA_W-1:0] rd_q;
        // Result register loaded by each valid operation
        always_ff @(posedge clk) begin
            if (!rst_n)       rd_q <= '0;
            else if (valid_i) rd_q <= res;
        end
        assign rd_o = rd_q;
    end else begin : g_comb
        assign rd_o = res;
    end

endmodule

// File: rtl/simd16_shift_unit_chk.sv
// Port-level checks for the packed shift unit, attached by bind.
module simd16_shift_unit_chk #(
    parameter int LANE_W     = 16,
    parameter int LANES      = 2,
    parameter bit REGISTERED = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic [2:0]  op_i,
    input logic [31:0] rs1_i,
    input logic [31:0] rs2_i,
    input logic [4:0]  imm_i,
    input logic        use_imm_i,
    input logic        sat_clr_i,
    input logic [31:0] rd_o,
    input logic        sat_o
);
    function automatic logic [31:0] msb_mask();
        logic [31:0] m = '0;
        for (int i = 0; i < LANES; i++) m[i*LANE_W + LANE_W - 1] = 1'b1;
        return m;
    endfunction
    localparam logic [31:0] MSBS = msb_mask();

    logic plain_op;
    assign plain_op = valid_i && (op_i <= 3'd2) && !(use_imm_i && imm_i[4]);

    assert_sat_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_o && !sat_clr_i) |=> sat_o);
    assert_sat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clr_i && !valid_i) |=> !sat_o);
    assert_sat_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_o) |-> $past(valid_i));
    assert_plain_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_op && !sat_o) |=> !sat_o);
    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> !sat_o);

    if (REGISTERED) begin : g_reg_chk
        assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_i |=> $stable(rd_o));
        assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && op_i == 3'd1 && !use_imm_i && rs2_i[3:0] != 4'd0)
            |=> ((rd_o & MSBS) == 32'd0));
    end else begin : g_comb_chk
        assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd1 && !use_imm_i && rs2_i[3:0] != 4'd0)
            |-> ((rd_o & MSBS) == 32'd0));
    end

endmodule

bind simd16_shift_unit simd16_shift_unit_chk #(
    .LANE_W(LANE_W), .LANES(LANES), .REGISTERED(REGISTERED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .rs1_i(rs1_i),
    .rs2_i(rs2_i), .imm_i(imm_i), .use_imm_i(use_imm_i), .sat_clr_i(sat_clr_i),
    .rd_o(rd_o), .sat_o(sat_o)
);

// File: tb/simd16_shift_unit_test.sv
`timescale 1ns/1ps
module simd16_shift_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [31:0] rs1_i = '0;
    logic [31:0] rs2_i = '0;
    logic [4:0]  imm_i = '0;
    logic        use_imm_i = 1'b0;
    logic        sat_clr_i = 1'b0;
    logic [31:0] rd_r, rd_c;
    logic        sat_r, sat_c;

    int checks = 0;
    int fails  = 0;
    logic        exp_sat = 1'b0;
    logic [31:0] last_rd = '0;

    always #10 clk = ~clk;

    simd16_shift_unit #(.REGISTERED(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .rs1_i(rs1_i),
        .rs2_i(rs2_i), .imm_i(imm_i), .use_imm_i(use_imm_i), .sat_clr_i(sat_clr_i),
        .rd_o(rd_r), .sat_o(sat_r));

    simd16_shift_unit #(.REGISTERED(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .rs1_i(rs1_i),
        .rs2_i(rs2_i), .imm_i(imm_i), .use_imm_i(use_imm_i), .sat_clr_i(sat_clr_i),
        .rd_o(rd_c), .sat_o(sat_c));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Reference model of one lane: {overflow, result}
    function automatic logic [16:0] ref_lane(input logic [2:0] op, input logic [15:0] a,
            input logic [31:0] rs2, input logic [4:0] imm, input logic use_imm);
        int n, eop, d, rb, sa, ua;
        logic [15:0] r;
        logic s;
        logic stop;
        s = 1'b0;
        sa = $signed(a);
        ua = int'(a);
        eop = int'(op);
        n = use_imm ? int'(imm[3:0]) : int'(rs2[3:0]);
        if (use_imm && imm[4] && op <= 3'd2) eop = eop + 3;
        if (op >= 3'd6) begin
            d = rs2[4] ? int'(rs2[4:0]) - 32 : int'(rs2[4:0]);
            if (d >= 0) begin eop = 5; n = d; end
            else begin
                n = -d;
                if (n == 16) n = 15;
                eop = (op == 3'd7) ? 3 : 0;
            end
        end
        case (eop)
            0: r = 16'(sa >>> n);
            1: r = 16'(ua >> n);
            2: r = 16'(ua << n);
            3: r = (n == 0) ? a : 16'((sa + (1 << (n - 1))) >>> n);
            4: r = (n == 0) ? a : 16'((ua + (1 << (n - 1))) >> n);
            default: begin
                rb = 0;
                stop = 1'b0;
                for (int i = 14; i >= 0; i--) begin
                    if (!stop && a[i] == a[15]) rb++;
                    else stop = 1'b1;
                end
                if (n > rb) begin
                    s = 1'b1;
                    r = a[15] ? 16'h8000 : 16'h7FFF;
                end else r = 16'(ua << n);
            end
        endcase
        return {s, r};
    endfunction

    // Issue one operation and check both copies at their own timing
    task automatic apply(input string req, input logic [2:0] op, input logic [31:0] a,
            input logic [31:0] b, input logic [4:0] imm, input logic ui, input logic clr);
        logic [16:0] l0, l1;
        logic [31:0] exp;
        l0 = ref_lane(op, a[15:0], b, imm, ui);
        l1 = ref_lane(op, a[31:16], b, imm, ui);
        exp = {l1[15:0], l0[15:0]};
        @(negedge clk);
        valid_i = 1'b1; op_i = op; rs1_i = a; rs2_i = b; imm_i = imm;
        use_imm_i = ui; sat_clr_i = clr;
        #1 check({req, " comb R9"}, rd_c, exp);
        @(posedge clk);
        if (l0[16] || l1[16]) exp_sat = 1'b1;
        else if (clr) exp_sat = 1'b0;
        #1;
        check({req, " reg R9"}, rd_r, exp);
        check("R8 sat reg", {31'd0, sat_r}, {31'd0, exp_sat});
        check("R8 sat comb", {31'd0, sat_c}, {31'd0, exp_sat});
        last_rd = exp;
        @(negedge clk);
        sat_clr_i = 1'b0;
    endtask

    task automatic clear_sat();
        @(negedge clk);
        valid_i = 1'b0; sat_clr_i = 1'b1;
        @(posedge clk); #1;
        exp_sat = 1'b0;
        check("R8 clear", {31'd0, sat_r}, 32'd0);
        @(negedge clk);
        sat_clr_i = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] corner [4];
        corner[0] = 16'h7FFF; corner[1] = 16'h8000; corner[2] = 16'hFFFF; corner[3] = 16'h0001;
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset rd", rd_r, 32'd0);
        check("R10 reset sat", {31'd0, sat_r}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R4: per-lane fills
        apply("R1 R4 asr", 3'd0, 32'h8000_7FFF, 32'd4, 5'd0, 1'b0, 1'b0);
        apply("R4 lsr", 3'd1, 32'h8000_FFFF, 32'd15, 5'd0, 1'b0, 1'b0);
        apply("R4 shl drops", 3'd2, 32'h7FFF_8001, 32'd1, 5'd0, 1'b0, 1'b0);
        // R2: upper rs2 bits ignored
        apply("R2 amount mask", 3'd0, 32'h8000_4000, 32'hFFFF_FFF3, 5'd0, 1'b0, 1'b0);
        // R3: immediate amount and variant promotion; bidir ignores immediate
        apply("R3 imm plain", 3'd1, 32'h1234_FFFF, 32'd0, 5'h01, 1'b1, 1'b0);
        apply("R3 imm rnd", 3'd1, 32'h0003_FFFF, 32'd0, 5'h11, 1'b1, 1'b0);
        apply("R3 bidir no imm", 3'd6, 32'h0001_0002, 32'd2, 5'h1F, 1'b1, 1'b0);
        // R5: rounding
        apply("R5 rnd asr 1", 3'd3, 32'h7FFF_FFFF, 32'd1, 5'd0, 1'b0, 1'b0);
        apply("R5 rnd lsr 1", 3'd4, 32'hFFFF_0001, 32'd1, 5'd0, 1'b0, 1'b0);
        apply("R5 rnd 0", 3'd3, 32'h8000_7FFF, 32'd0, 5'd0, 1'b0, 1'b0);
        apply("R5 rnd 15", 3'd3, 32'h8000_4000, 32'd15, 5'd0, 1'b0, 1'b0);
        // R6: clamping left shift
        apply("R6 no ovf", 3'd5, 32'h0001_FFFF, 32'd14, 5'd0, 1'b0, 1'b0);
        apply("R6 ovf", 3'd5, 32'h0001_8000, 32'd15, 5'd0, 1'b0, 1'b0);
        clear_sat();
        apply("R6 imm ovf", 3'd2, 32'h4000_0000, 32'd0, 5'h11, 1'b1, 1'b0);
        // R8: set wins over clear in the same cycle
        apply("R8 set over clear", 3'd5, 32'h7FFF_0000, 32'd1, 5'd0, 1'b0, 1'b1);
        apply("R8 clear with op", 3'd0, 32'h7FFF_0000, 32'd1, 5'd0, 1'b0, 1'b1);
        // R7: bidirectional amounts 0, 1, 15, -1, -15, -16
        foreach (corner[i]) begin
            for (int k = 0; k < 6; k++) begin
                logic [4:0] amts [6];
                amts[0] = 5'd0; amts[1] = 5'd1; amts[2] = 5'd15;
                amts[3] = 5'h1F; amts[4] = 5'h11; amts[5] = 5'h10;
                apply("R7 bidir", 3'd6, {corner[i], corner[(i + 1) % 4]}, {27'd0, amts[k]}, 5'd0, 1'b0, 1'b0);
                apply("R7 bidir rnd", 3'd7, {corner[i], corner[(i + 2) % 4]}, {27'd0, amts[k]}, 5'd0, 1'b0, 1'b0);
                clear_sat();
            end
            for (int op = 0; op < 6; op++) begin
                apply("R1 corner 0", 3'(op), {corner[i], corner[3 - i]}, 32'd0, 5'd0, 1'b0, 1'b0);
                apply("R1 corner 1", 3'(op), {corner[i], corner[3 - i]}, 32'd1, 5'd0, 1'b0, 1'b0);
                apply("R1 corner 15", 3'(op), {corner[i], corner[3 - i]}, 32'd15, 5'd0, 1'b0, 1'b0);
            end
            clear_sat();
        end
        // R9: hold while idle
        @(negedge clk);
        valid_i = 1'b0; rs1_i = 32'hDEAD_BEEF; op_i = 3'd2; rs2_i = 32'd3;
        @(posedge clk); #1;
        check("R9 hold", rd_r, last_rd);
        // Random mix
        for (int v = 0; v < 600; v++) begin
            logic [31:0] a;
            a = $urandom;
            if ($urandom % 4 == 0) a[15:0] = corner[$urandom % 4];
            apply("R1 random", 3'($urandom % 8), a, $urandom, 5'($urandom), 1'($urandom),
                  ($urandom % 8) == 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule